// File: doc/BRIEF.md
# Two-Master Bus Ownership Arbiter

This block decides which of two masters drives a shared external bus: the on-chip processor or one external device. Each side signals its wish with an active-low request and is answered by a grant. Both sides share one open-drain bus-busy line, modelled here as the AND of each master's active-low drive. A master may take the bus only when it holds a grant and has sampled bus-busy released. It then drives bus-busy low for as long as it owns the bus.

A strap input is captured while reset is asserted and chooses between two modes. In internal mode the block's own fixed-priority arbiter issues the grants, and the external master ranks above the processor. In external mode that arbiter is held idle, and the processor's request and grant pass to and from a central arbiter elsewhere. In both modes the block runs the processor's ownership handshake. While the processor's atomic input is asserted, it keeps the bus through a multi-beat or split sequence even if its grant is taken away. When the processor is the only requester its grant stays parked, so back-to-back cycles need no new arbitration.

The arbiter has three states. ARB_IDLE issues no grant. ARB_CPU grants the processor and also serves as the parked state. ARB_EXT grants the external master. Its transitions are:
- ARB_IDLE to ARB_EXT on an external request.
- ARB_IDLE to ARB_CPU on a processor request when no external request is present.
- ARB_CPU to ARB_EXT on an external request, unless the processor is locked.
- ARB_EXT to ARB_CPU when the external request goes away and the processor is requesting.
- ARB_EXT to ARB_IDLE when neither master is requesting.

The ownership machine also has three states. OWN_IDLE means no request. OWN_WAIT means requesting and waiting for a grant with bus-busy released. OWN_HOLD means driving bus-busy as owner. Its transitions are:
- OWN_IDLE to OWN_WAIT on a request.
- OWN_WAIT to OWN_IDLE if the request is dropped.
- OWN_WAIT to OWN_HOLD when the grant is held and the bus is free.
- OWN_HOLD stays while the current cycle is running or the atomic input is high.
- At the end of a non-atomic cycle, OWN_HOLD goes to OWN_HOLD if the request and grant are both still held, to OWN_WAIT if only the request is held, and to OWN_IDLE otherwise.

Top module: `bus_arb_ctrl`

## Requirements
- R1: The mode is the value of `ext_arb_strap` at the last clock edge with `rst_n` low (1 = external arbiter, 0 = internal arbiter). Later changes of the strap have no effect until the next reset.
- R2: In internal mode, if `ext_req_n` is sampled low while the processor is not locked, `ext_gnt_n` goes low one clock later. The external master has priority over the processor.
- R3: In internal mode, a processor grant stays parked while no external request is present. A non-atomic cycle end with `cpu_req` still high keeps `cpu_own` high without a gap, and `ext_gnt_n` stays high.
- R4: `cpu_own` rises only one clock after an edge at which the processor had a grant and `busy_n` was high. While `ext_busy_n` is low, the processor does not take the bus.
- R5: The owner keeps `cpu_own` until the edge that samples `cpu_done` with `cpu_atomic` low. If `cpu_req` is low or the grant is gone at that edge, `cpu_own` and its bus-busy drive drop one clock later.
- R6: While `cpu_own` and `cpu_atomic` are both high, the processor keeps ownership through `cpu_done`, even with its grant withdrawn. In internal mode, `ext_gnt_n` stays high during that time.
- R7: After losing its grant, the processor regains ownership only after a new grant and a sampled release of bus-busy.
- R8: In external mode, `ext_gnt_n` stays high. `cpu_ext_req_n` equals the inverse of `cpu_req`, and the processor's grant is `cpu_ext_gnt_n` low. In internal mode, `cpu_ext_req_n` stays high.
- R9: `busy_n` is low exactly when `cpu_own` is high or `ext_busy_n` is low.
- R10: During and right after reset, `cpu_own` is low and `ext_gnt_n` is high.
- R11: In internal mode, `ext_gnt_n` returns high one clock after `ext_req_n` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_arb_strap | input | 1 | Mode strap, captured during reset (1 = external arbiter) |
| cpu_req | input | 1 | Processor wants the bus (active high) |
| cpu_atomic | input | 1 | Processor is in an atomic sequence; holds ownership |
| cpu_done | input | 1 | Processor's current bus cycle ends this clock |
| cpu_own | output | 1 | Processor owns the bus and may run cycles |
| ext_req_n | input | 1 | External master bus request, active low |
| ext_gnt_n | output | 1 | External master bus grant, active low |
| ext_busy_n | input | 1 | External master's bus-busy drive, active low |
| busy_n | output | 1 | Resolved shared bus-busy line, active low |
| cpu_ext_req_n | output | 1 | Processor request to the central arbiter, active low |
| cpu_ext_gnt_n | input | 1 | Grant from the central arbiter to the processor, active low |

## Verification
Grant and ownership changes are registered. An input that the design samples at one edge therefore shows on `ext_gnt_n` and `cpu_own` from that edge until the next one. Requesting from an idle processor takes two edges, one into OWN_WAIT and one into OWN_HOLD. `busy_n` and `cpu_ext_req_n` follow their inputs in the same cycle. The bench drives inputs 2 ns after the falling edge and compares every output against a behavioural model on each falling edge. Each directed check is placed at the falling edge after the number of rising edges that its result needs.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_CPU  = 2'd1,
        ARB_EXT  = 2'd2
    } arb_state_t;

    typedef enum logic [1:0] {
        OWN_IDLE = 2'd0,
        OWN_WAIT = 2'd1,
        OWN_HOLD = 2'd2
    } own_state_t;
endpackage

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
    import bus_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ext_req,
    input  logic cpu_req,
    input  logic cpu_lock,
    output logic cpu_gnt,
    output logic ext_gnt
);
    arb_state_t state, state_nxt;

    // State register; the arbiter is held idle when internal mode is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) state <= ARB_IDLE;
        else                   state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ARB_IDLE: begin
                if (ext_req)      state_nxt = ARB_EXT;
                else if (cpu_req) state_nxt = ARB_CPU;
            end
            ARB_CPU: begin
                // Parked: moves only for the external master and never while locked.
                if (ext_req && !cpu_lock) state_nxt = ARB_EXT;
            end
            ARB_EXT: begin
                if (!ext_req) state_nxt = cpu_req ? ARB_CPU : ARB_IDLE;
            end
            default: state_nxt = ARB_IDLE;
        endcase
    end

    always_comb begin
        cpu_gnt = (state == ARB_CPU);
        ext_gnt = (state == ARB_EXT);
    end
endmodule

// File: rtl/cpu_owner_fsm.sv
module cpu_owner_fsm
    import bus_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic gnt,
    input  logic bus_free,
    input  logic atomic,
    input  logic done,
    output logic own,
    output logic lock
);
    own_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= OWN_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            OWN_IDLE: begin
                if (req) state_nxt = OWN_WAIT;
            end
            OWN_WAIT: begin
                if (!req)                 state_nxt = OWN_IDLE;
                else if (gnt && bus_free) state_nxt = OWN_HOLD;
            end
            OWN_HOLD: begin
                // Leave only at the end of a cycle outside an atomic sequence.
                if (done && !atomic) begin
                    if (req && gnt) state_nxt = OWN_HOLD;
                    else if (req)   state_nxt = OWN_WAIT;
                    else            state_nxt = OWN_IDLE;
                end
            end
            default: state_nxt = OWN_IDLE;
        endcase
    end

    always_comb begin
        own  = (state == OWN_HOLD);
        lock = (state == OWN_HOLD) && atomic;
    end
endmodule

// File: rtl/bus_arb_ctrl.sv
module bus_arb_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_arb_strap,
    input  logic cpu_req,
    input  logic cpu_atomic,
    input  logic cpu_done,
    output logic cpu_own,
    input  logic ext_req_n,
    output logic ext_gnt_n,
    input  logic ext_busy_n,
    output logic busy_n,
    output logic cpu_ext_req_n,
    input  logic cpu_ext_gnt_n
);
    logic ext_mode;
    logic int_cpu_gnt;
    logic int_ext_gnt;
    logic cpu_grant;
    logic cpu_lock;

    // Mode strap is captured only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_mode <= ext_arb_strap;
    end

    arb_grant_fsm u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (!ext_mode),
        .ext_req  (!ext_req_n),
        .cpu_req  (cpu_req),
        .cpu_lock (cpu_lock),
        .cpu_gnt  (int_cpu_gnt),
        .ext_gnt  (int_ext_gnt)
    );

    always_comb begin
        cpu_grant     = ext_mode ? !cpu_ext_gnt_n : int_cpu_gnt;
        cpu_ext_req_n = !(ext_mode && cpu_req);
        ext_gnt_n     = !int_ext_gnt;
        busy_n        = !cpu_own && ext_busy_n;
    end

    cpu_owner_fsm u_own (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (cpu_req),
        .gnt      (cpu_grant),
        .bus_free (busy_n),
        .atomic   (cpu_atomic),
        .done     (cpu_done),
        .own      (cpu_own),
        .lock     (cpu_lock)
    );
endmodule

// File: rtl/bus_arb_ctrl_chk.sv
module bus_arb_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_mode,
    input logic cpu_grant,
    input logic cpu_req,
    input logic cpu_atomic,
    input logic cpu_done,
    input logic cpu_own,
    input logic ext_gnt_n,
    input logic busy_n
);
    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(ext_mode));

    // R4
    take_after_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_own) |-> ($past(busy_n) && $past(cpu_grant)));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_own && cpu_done && !cpu_atomic && !cpu_req) |=> !cpu_own);

    // R3
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_own && cpu_done && !cpu_atomic && cpu_req && cpu_grant) |=> cpu_own);

    // R6
    atomic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_own && cpu_atomic) |=> cpu_own);

    // R6
    atomic_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_own && cpu_atomic && ext_gnt_n) |=> ext_gnt_n);

    // R8
    ext_mode_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |-> ext_gnt_n);

    // R9
    busy_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_own |-> !busy_n);
endmodule

bind bus_arb_ctrl bus_arb_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_mode   (ext_mode),
    .cpu_grant  (cpu_grant),
    .cpu_req    (cpu_req),
    .cpu_atomic (cpu_atomic),
    .cpu_done   (cpu_done),
    .cpu_own    (cpu_own),
    .ext_gnt_n  (ext_gnt_n),
    .busy_n     (busy_n)
);

// File: tb/bus_arb_ctrl_tb_top.sv
module bus_arb_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n, ext_arb_strap, cpu_req, cpu_atomic, cpu_done;
    logic ext_req_n, ext_busy_n, cpu_ext_gnt_n;
    logic cpu_own, ext_gnt_n, busy_n, cpu_ext_req_n;

    int n_chk = 0;
    int n_fail = 0;
    bit started = 1'b0;

    // Behavioural reference state
    bit m_mode;
    int m_arb;   // 0 none, 1 processor, 2 external
    int m_own;   // 0 idle, 1 waiting, 2 owning

    always #4 clk = ~clk;

    bus_arb_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ext_arb_strap(ext_arb_strap),
        .cpu_req(cpu_req), .cpu_atomic(cpu_atomic), .cpu_done(cpu_done),
        .cpu_own(cpu_own), .ext_req_n(ext_req_n), .ext_gnt_n(ext_gnt_n),
        .ext_busy_n(ext_busy_n), .busy_n(busy_n),
        .cpu_ext_req_n(cpu_ext_req_n), .cpu_ext_gnt_n(cpu_ext_gnt_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int na, no;
        bit gnt, free, lck;
        started = 1'b1;
        if (!rst_n) begin
            m_mode = ext_arb_strap; m_arb = 0; m_own = 0;
        end else begin
            lck  = (m_own == 2) && cpu_atomic;
            gnt  = m_mode ? !cpu_ext_gnt_n : (m_arb == 1);
            free = (m_own != 2) && ext_busy_n;
            if (m_mode)           na = 0;
            else if (m_arb == 0)  na = !ext_req_n ? 2 : (cpu_req ? 1 : 0);
            else if (m_arb == 1)  na = (!ext_req_n && !lck) ? 2 : 1;
            else                  na = ext_req_n ? (cpu_req ? 1 : 0) : 2;
            no = m_own;
            if (m_own == 0)       no = cpu_req ? 1 : 0;
            else if (m_own == 1)  no = !cpu_req ? 0 : ((gnt && free) ? 2 : 1);
            else if (cpu_done && !cpu_atomic)
                no = (cpu_req && gnt) ? 2 : (cpu_req ? 1 : 0);
            m_arb = na; m_own = no;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            chk("R2", ext_gnt_n, !(m_arb == 2));
            chk("R4", cpu_own, m_own == 2);
            chk("R9", busy_n, (m_own != 2) && ext_busy_n);
            chk("R8", cpu_ext_req_n, !(m_mode && cpu_req));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; ext_arb_strap = 0; cpu_req = 0; cpu_atomic = 0; cpu_done = 0;
        ext_req_n = 1; ext_busy_n = 1; cpu_ext_gnt_n = 1;
        repeat (3) @(negedge clk);
        chk("R10", cpu_own, 1'b0);
        chk("R10", ext_gnt_n, 1'b1);
        #2 rst_n = 1;
        @(negedge clk);
        chk("R10", cpu_own, 1'b0);
        // R1: strap moves after reset, mode stays internal
        #2 ext_arb_strap = 1; cpu_req = 1;
        @(negedge clk);
        chk("R1", cpu_ext_req_n, 1'b1);
        chk("R4", cpu_own, 1'b0);
        @(negedge clk);
        chk("R4", cpu_own, 1'b1);
        chk("R9", busy_n, 1'b0);
        // R3: back-to-back with parked grant
        #2 cpu_done = 1;
        @(negedge clk);
        chk("R3", cpu_own, 1'b1);
        chk("R3", ext_gnt_n, 1'b1);
        // R6: atomic sequence blocks the external grant
        #2 cpu_done = 0; cpu_atomic = 1; ext_req_n = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6", ext_gnt_n, 1'b1);
            chk("R6", cpu_own, 1'b1);
        end
        #2 cpu_done = 1;
        @(negedge clk);
        chk("R6", cpu_own, 1'b1);
        // Lock drops mid-cycle: grant moves, ownership stays until done
        #2 cpu_done = 0; cpu_atomic = 0;
        @(negedge clk);
        chk("R2", ext_gnt_n, 1'b0);
        chk("R5", cpu_own, 1'b1);
        #2 cpu_done = 1;
        @(negedge clk);
        chk("R5", cpu_own, 1'b0);
        chk("R5", busy_n, 1'b1);
        // External master takes the bus
        #2 cpu_done = 0; ext_busy_n = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R7", cpu_own, 1'b0);
        end
        #2 ext_busy_n = 1; ext_req_n = 1;
        @(negedge clk);
        chk("R11", ext_gnt_n, 1'b1);
        chk("R7", cpu_own, 1'b0);
        @(negedge clk);
        chk("R7", cpu_own, 1'b1);
        // Release with no request
        #2 cpu_req = 0; cpu_done = 1;
        @(negedge clk);
        chk("R5", cpu_own, 1'b0);
        // Foreign bus-busy blocks the take
        #2 cpu_done = 0; ext_busy_n = 0; cpu_req = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R4", cpu_own, 1'b0);
        end
        #2 ext_busy_n = 1;
        @(negedge clk);
        chk("R4", cpu_own, 1'b1);
        chk("R3", ext_gnt_n, 1'b1);
        #2 cpu_req = 0; cpu_done = 1;
        @(negedge clk);
        // External request with idle processor, then withdrawn
        #2 cpu_done = 0; ext_req_n = 0;
        @(negedge clk);
        chk("R2", ext_gnt_n, 1'b0);
        #2 ext_req_n = 1;
        @(negedge clk);
        chk("R11", ext_gnt_n, 1'b1);

        // External arbiter mode
        #2 rst_n = 0; ext_arb_strap = 1;
        repeat (2) @(negedge clk);
        chk("R10", cpu_own, 1'b0);
        #2 rst_n = 1; ext_arb_strap = 0; ext_req_n = 0;
        @(negedge clk);
        chk("R8", ext_gnt_n, 1'b1);
        #2 cpu_req = 1;
        @(negedge clk);
        chk("R1", cpu_ext_req_n, 1'b0);
        chk("R8", cpu_own, 1'b0);
        @(negedge clk);
        chk("R8", cpu_own, 1'b0);
        #2 cpu_ext_gnt_n = 0;
        @(negedge clk);
        chk("R8", cpu_own, 1'b1);
        #2 cpu_ext_gnt_n = 1; cpu_atomic = 1; cpu_done = 1;
        @(negedge clk);
        chk("R6", cpu_own, 1'b1);
        #2 cpu_atomic = 0;
        @(negedge clk);
        chk("R7", cpu_own, 1'b0);
        #2 cpu_done = 0; cpu_req = 0; ext_req_n = 1;
        repeat (3) @(negedge clk);
        chk("R8", ext_gnt_n, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule